// File: doc/BRIEF.md
# Configuration Register Bank with Two-Wire Block-Write Slave

This block is a two-wire (I2C/SMBus) slave that owns 23 byte-wide configuration registers for a programmable clock synthesizer. Registers are written only with block writes: after the address byte, the host sends a command byte and a byte-count byte, and the slave skips both. Each following data byte lands in the next register, beginning at register 0 and counting upward. This continues until the host ends the transfer with a Stop or a repeated Start. The host may end the transfer after any whole byte.

Incoming bytes are first held in a shadow copy. When the transfer ends, they are committed together. Three register groups (14–15, 16–17 and 18–20) are committed only when every byte of the group was received, so a group that is cut short leaves the live values as they were. A block read returns a count byte followed by that many registers, starting at register 0. The count is held in register 6.

The parallel register outputs feed the synthesizer directly. The bus pins are SCL and SDA. For SDA, the block drives only an active-low enable, so the board pull-up supplies the high level.

Top module: `cfg_bank_slave`

## Requirements
- R1: The 7-bit address matching `DEV_ADDR` is acknowledged, and so is every byte of a write to it. Any other address gets no acknowledge (SDA stays released).
- R2: The two bytes after a write address (command and byte count) are discarded whatever their values. The third byte goes to register 0, the fourth to register 1, and so on upward. Bytes past register 22 are dropped.
- R3: Register outputs change only in the cycles that follow the end of a write transfer (Stop or repeated Start). Received bytes for registers outside any group are all committed at that point.
- R4: Registers 14–15, 16–17 and 18–20 are each committed only when the transfer delivered the highest-numbered byte of that group. Otherwise none of the group's registers changes.
- R5: Register 6 resets to 0x06. A write of 0x00 to it is refused and the previous value is kept.
- R6: Bits [3:0] of register 11 always read 0001. Bits [7:4] of register 11 and all of register 12 hold fixed revision values. Writes to registers 11 and 12 are ignored.
- R7: Registers 10 and 13 accept write bytes but always read 0x00.
- R8: Register 7 holds the bitwise inverse of `strap_i`, captured while reset is asserted. Writes to register 7 are ignored.
- R9: After reset, register 9 reads 0xFF, register 8 reads 0x00, and the other writable registers read 0x00.
- R10: A read to the address (R/W bit 1) returns the register-6 count first, then registers 0 upward. After that many data bytes have been acknowledged, or after the host sends a NACK, the slave stops driving SDA. Following clocked bits then read as 1.
- R11: A byte interrupted by Stop before its eighth bit is not stored, and the bytes before it still commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast relative to SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level from the pin |
| sda_i | input | 1 | SDA level from the pin |
| sda_oe | output | 1 | When high, pull SDA low |
| strap_i | input | 8 | Input pin levels sampled during reset |
| regs_o | output | NREG*8 | Live registers, register k at bits [8k+7:8k] |

## Verification
The assertions assume that SCL and SDA change much more slowly than `clk`, so each bus edge reaches the synchronizer as one clean transition. They also assume that SDA moves while SCL is high only to form a Start or a Stop. The bench's bus master holds every SCL phase for twelve system clocks. It changes SDA only in the low phase, except when it deliberately forms Start, repeated Start and Stop. The master always releases SDA whenever the slave is supposed to drive it.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  typedef enum logic [2:0] {
    LS_IDLE, LS_ADDR, LS_AACK, LS_WDAT, LS_WACK, LS_RDAT, LS_RACK, LS_RNXT
  } link_st_t;

  localparam int REG_RBCNT  = 6;
  localparam int REG_STRAP  = 7;
  localparam int REG_WDOG_T = 9;
  localparam int REG_RSV_A  = 10;
  localparam int REG_ID_A   = 11;
  localparam int REG_ID_B   = 12;
  localparam int REG_RSV_B  = 13;

  // last index of the commit group a register belongs to
  function automatic int grp_end(int i);
    if (i == 14 || i == 15) return 15;
    if (i == 16 || i == 17) return 17;
    if (i >= 18 && i <= 20) return 20;
    return i;
  endfunction

  function automatic bit is_fixed(int i);
    return (i == REG_RSV_A) || (i == REG_ID_A) || (i == REG_ID_B) || (i == REG_RSV_B);
  endfunction

  function automatic logic [7:0] reg_default(int i, logic [3:0] rev_hi, logic [7:0] rev_lo);
    if (i == REG_RBCNT)  return 8'h06;
    if (i == REG_WDOG_T) return 8'hFF;
    if (i == REG_ID_A)   return {rev_hi, 4'b0001};
    if (i == REG_ID_B)   return rev_lo;
    return 8'h00;
  endfunction

endpackage

// File: rtl/cb_line_mon.sv
module cb_line_mon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_r,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC-1:0] scl_s, sda_s;
  logic scl_q;
  logic scl_now, sda_now;

  assign scl_now = scl_s[SYNC-1];
  assign sda_now = sda_s[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_s     <= '1;
      sda_s     <= '1;
      scl_q     <= 1'b1;
      sda_r     <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_evt <= 1'b0;
      stop_evt  <= 1'b0;
    end else begin
      scl_s     <= {scl_s[SYNC-2:0], scl_i};
      sda_s     <= {sda_s[SYNC-2:0], sda_i};
      scl_q     <= scl_now;
      sda_r     <= sda_now;
      scl_rise  <= scl_now & ~scl_q;
      scl_fall  <= ~scl_now & scl_q;
      start_evt <= scl_now & scl_q & sda_r & ~sda_now;
      stop_evt  <= scl_now & scl_q & ~sda_r & sda_now;
    end
  end
endmodule

// File: rtl/cb_link.sv
module cb_link
  import cfgbank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_r,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] rd_data,
  input  logic [7:0] cnt_val,
  output logic [7:0] rd_idx,
  output logic       wr_stb,
  output logic [7:0] wr_data,
  output logic       xfer_begin,
  output logic       commit,
  output logic       sda_oe
);
  link_st_t    st;
  logic [3:0]  bitc;
  logic [7:0]  sh;
  logic [6:0]  tx;
  logic [1:0]  hdr;
  logic        is_wr, rd_mode;

  always_ff @(posedge clk) begin
    wr_stb     <= 1'b0;
    xfer_begin <= 1'b0;
    commit     <= 1'b0;
    if (rst) begin
      st <= LS_IDLE; sda_oe <= 1'b0; bitc <= '0; sh <= '0; tx <= '0;
      hdr <= '0; is_wr <= 1'b0; rd_mode <= 1'b0; rd_idx <= '0; wr_data <= '0;
    end else if (start_evt || stop_evt) begin
      commit <= is_wr;
      is_wr  <= 1'b0;
      sda_oe <= 1'b0;
      bitc   <= '0;
      st     <= start_evt ? LS_ADDR : LS_IDLE;
    end else begin
      case (st)
        LS_ADDR, LS_WDAT: begin
          if (scl_rise) begin
            sh   <= {sh[6:0], sda_r};
            bitc <= bitc + 4'd1;
          end else if (scl_fall && bitc == 4'd8) begin
            bitc <= '0;
            if (st == LS_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe  <= 1'b1;
                st      <= LS_AACK;
                rd_mode <= sh[0];
                rd_idx  <= '0;
                if (!sh[0]) begin
                  is_wr      <= 1'b1;
                  xfer_begin <= 1'b1;
                  hdr        <= '0;
                end
              end else begin
                st <= LS_IDLE;
              end
            end else begin
              sda_oe  <= 1'b1;
              st      <= LS_WACK;
              wr_data <= sh;
              if (hdr == 2'd2) wr_stb <= 1'b1;
              else             hdr    <= hdr + 2'd1;
            end
          end
        end
        LS_AACK: if (scl_fall) begin
          if (rd_mode) begin
            tx <= rd_data[6:0]; sda_oe <= ~rd_data[7]; st <= LS_RDAT;
          end else begin
            sda_oe <= 1'b0; st <= LS_WDAT;
          end
        end
        LS_WACK: if (scl_fall) begin
          sda_oe <= 1'b0; st <= LS_WDAT;
        end
        LS_RDAT: begin
          if (scl_rise) bitc <= bitc + 4'd1;
          else if (scl_fall) begin
            if (bitc == 4'd8) begin
              bitc <= '0; sda_oe <= 1'b0; st <= LS_RACK;
            end else begin
              tx <= {tx[5:0], 1'b0}; sda_oe <= ~tx[6];
            end
          end
        end
        LS_RACK: if (scl_rise) begin
          if (sda_r || rd_idx == cnt_val) st <= LS_IDLE;
          else begin
            rd_idx <= rd_idx + 8'd1; st <= LS_RNXT;
          end
        end
        LS_RNXT: if (scl_fall) begin
          tx <= rd_data[6:0]; sda_oe <= ~rd_data[7]; st <= LS_RDAT;
        end
        default: st <= LS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cb_regfile.sv
module cb_regfile
  import cfgbank_pkg::*;
#(
  parameter int         NREG   = 23,
  parameter logic [3:0] REV_HI = 4'h2,
  parameter logic [7:0] REV_LO = 8'h35
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [7:0]      strap_i,
  input  logic            wr_stb,
  input  logic [7:0]      wr_data,
  input  logic            xfer_begin,
  input  logic            commit,
  input  logic [7:0]      rd_sel,
  output logic [7:0]      rd_data,
  output logic [7:0]      cnt_val,
  output logic [NREG*8-1:0] regs_o
);
  localparam int IW = $clog2(NREG + 1);

  logic [7:0]    shadow [NREG];
  logic [7:0]    live   [NREG];
  logic [IW-1:0] fill;
  logic          room;

  assign room = fill < IW'(NREG);

  always_ff @(posedge clk) begin
    if (wr_stb && room) shadow[fill] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || xfer_begin || commit) fill <= '0;
    else if (wr_stb && room)         fill <= fill + 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int         LAST = grp_end(g);
    localparam logic [7:0] DEF  = reg_default(g, REV_HI, REV_LO);
    logic [7:0] q;
    if (g == REG_STRAP) begin : g_strap
      always_ff @(posedge clk) if (rst) q <= ~strap_i;
    end else if (is_fixed(g)) begin : g_fixed
      assign q = DEF;
    end else begin : g_rw
      logic take;
      assign take = commit && (int'(fill) > LAST) &&
                    ((g != REG_RBCNT) || (shadow[g] != 8'h00));
      always_ff @(posedge clk) begin
        if (rst)       q <= DEF;
        else if (take) q <= shadow[g];
      end
    end
    assign live[g] = q;
    assign regs_o[g*8 +: 8] = q;
  end

  assign cnt_val = live[REG_RBCNT];

  always_comb begin
    rd_data = 8'h00;
    if (rd_sel == 8'd0) rd_data = live[REG_RBCNT];
    for (int k = 0; k < NREG; k++)
      if (rd_sel == 8'(k + 1)) rd_data = live[k];
  end
endmodule

// File: rtl/cfg_bank_slave.sv
module cfg_bank_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 23,
  parameter int         SYNC     = 2,
  parameter logic [3:0] REV_HI   = 4'h2,
  parameter logic [7:0] REV_LO   = 8'h35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [7:0]        strap_i,
  output logic [NREG*8-1:0] regs_o
);
  localparam int REGS_W = NREG * 8;

  logic sda_r, scl_rise, scl_fall, start_w, stop_w;
  logic wr_stb, xfer_begin, commit_w;
  logic [7:0] wr_data, rd_idx, rd_data, cnt_val;
  logic [REGS_W-1:0] regs_w;

  cb_line_mon #(.SYNC(SYNC)) u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_r(sda_r),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_w), .stop_evt(stop_w)
  );

  cb_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst(rst), .sda_r(sda_r), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_w), .stop_evt(stop_w), .rd_data(rd_data), .cnt_val(cnt_val),
    .rd_idx(rd_idx), .wr_stb(wr_stb), .wr_data(wr_data), .xfer_begin(xfer_begin),
    .commit(commit_w), .sda_oe(sda_oe)
  );

  cb_regfile #(.NREG(NREG), .REV_HI(REV_HI), .REV_LO(REV_LO)) u_rf (
    .clk(clk), .rst(rst), .strap_i(strap_i), .wr_stb(wr_stb), .wr_data(wr_data),
    .xfer_begin(xfer_begin), .commit(commit_w), .rd_sel(rd_idx), .rd_data(rd_data),
    .cnt_val(cnt_val), .regs_o(regs_w)
  );

  assign regs_o = regs_w;
endmodule

// File: rtl/cfg_bank_checker.sv
module cfg_bank_checker
  import cfgbank_pkg::*;
#(
  parameter int NREG = 23
) (
  input logic              clk,
  input logic              rst,
  input logic [NREG*8-1:0] regs_o,
  input logic              sda_oe,
  input logic              commit,
  input logic              stop_evt
);
  assert_regs_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(regs_o));

  assert_cnt_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    regs_o[REG_RBCNT*8 +: 8] != 8'h00);

  assert_id_nibble_R6: assert property (@(posedge clk) disable iff (rst)
    regs_o[REG_ID_A*8 +: 4] == 4'b0001);

  assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (rst)
    regs_o[REG_RSV_A*8 +: 8] == 8'h00 && regs_o[REG_RSV_B*8 +: 8] == 8'h00);

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);
endmodule

bind cfg_bank_slave cfg_bank_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .regs_o(regs_o), .sda_oe(sda_oe),
  .commit(commit_w), .stop_evt(stop_w)
);

// File: tb/sim_cfg_bank_slave.sv
`timescale 1ns/1ps
module sim_cfg_bank_slave;
  localparam logic [6:0] ADDR   = 7'h69;
  localparam int         NR     = 23;
  localparam logic [3:0] RV_HI  = 4'h2;
  localparam logic [7:0] RV_LO  = 8'h35;
  localparam logic [7:0] STRAP  = 8'h5A;
  localparam int         Q      = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs_o;
  wire  sda_w = sda_m & ~sda_oe;

  int checks = 0, failures = 0;
  logic settle = 1'b1;
  logic [7:0] mdl [NR];

  always #2.5 clk = ~clk;

  cfg_bank_slave #(.DEV_ADDR(ADDR), .NREG(NR), .REV_HI(RV_HI), .REV_LO(RV_LO)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_w), .sda_oe(sda_oe),
    .strap_i(STRAP), .regs_o(regs_o)
  );

  function automatic logic [7:0] reg_at(int i);
    return regs_o[i*8 +: 8];
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  // reference: commit a list of received data bytes per the requirements
  task automatic model_apply(input logic [7:0] d[$]);
    int n = d.size();
    for (int i = 0; i < n && i < NR; i++) begin
      bit ok = 1'b1;
      if (i == 7 || i == 10 || i == 11 || i == 12 || i == 13) ok = 1'b0;
      if (i == 6 && d[i] == 8'h00) ok = 1'b0;
      if ((i == 14 || i == 15) && n < 16) ok = 1'b0;
      if ((i == 16 || i == 17) && n < 18) ok = 1'b0;
      if (i >= 18 && i <= 20 && n < 21) ok = 1'b0;
      if (ok) mdl[i] = d[i];
    end
  endtask

  // per-clock comparison of all registers against the model (R3)
  always @(negedge clk) begin
    if (!rst && !settle) begin
      logic [NR*8-1:0] flat;
      for (int i = 0; i < NR; i++) flat[i*8 +: 8] = mdl[i];
      checks++;
      if (regs_o !== flat) begin
        failures++;
        $display("FAIL R3 regs_o got=%h exp=%h", regs_o, flat);
      end
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q);
    settle = 1'b1; sda_m = 1'b1; hold(Q + 8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) begin
      sda_m = b[k]; hold(Q); scl_m = 1'b1; hold(Q); scl_m = 1'b0;
    end
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q/2);
    ack = ~sda_w; hold(Q/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    sda_m = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      hold(Q); scl_m = 1'b1; hold(Q/2); b[k] = sda_w; hold(Q/2); scl_m = 1'b0;
    end
    sda_m = nack; hold(Q); scl_m = 1'b1; hold(Q); scl_m = 1'b0; sda_m = 1'b1;
  endtask

  task automatic write_tx(input logic [7:0] d[$], input int part_bits, input logic [7:0] pv);
    logic ack;
    bus_start;
    send_byte({ADDR, 1'b0}, ack); chk("R1 addr ack", {7'd0, ack}, 8'd1);
    send_byte(8'hA5, ack);        chk("R1 cmd ack", {7'd0, ack}, 8'd1);
    send_byte(8'h3C, ack);        chk("R1 count ack", {7'd0, ack}, 8'd1);
    foreach (d[i]) begin
      send_byte(d[i], ack); chk("R1 data ack", {7'd0, ack}, 8'd1);
    end
    for (int k = 0; k < part_bits; k++) begin
      sda_m = pv[7-k]; hold(Q); scl_m = 1'b1; hold(Q); scl_m = 1'b0;
    end
    bus_stop;
    model_apply(d);
    settle = 1'b0;
  endtask

  initial begin
    logic [7:0] q[$];
    logic [7:0] b;
    logic ack;
    for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
    mdl[6] = 8'h06; mdl[7] = ~STRAP; mdl[9] = 8'hFF;
    mdl[11] = {RV_HI, 4'b0001}; mdl[12] = RV_LO;

    hold(5); rst = 1'b0; hold(5); settle = 1'b0;

    // reset state
    chk("R9 reg8 default", reg_at(8), 8'h00);
    chk("R9 reg9 default", reg_at(9), 8'hFF);
    chk("R9 reg0 default", reg_at(0), 8'h00);
    chk("R5 reg6 default", reg_at(6), 8'h06);
    chk("R8 reg7 strap", reg_at(7), ~STRAP);
    chk("R6 reg11 id", reg_at(11), {RV_HI, 4'b0001});
    chk("R6 reg12 rev", reg_at(12), RV_LO);
    chk("R1 no drive idle", {7'd0, sda_oe}, 8'd0);

    // foreign address: no acknowledge
    bus_start;
    send_byte({ADDR ^ 7'h01, 1'b0}, ack);
    chk("R1 foreign nack", {7'd0, ack}, 8'd0);
    bus_stop; settle = 1'b0;

    // full write of registers 0..20
    q = {};
    for (int i = 0; i < 21; i++) q.push_back(8'(i*37 + 11));
    q[6] = 8'h05;
    write_tx(q, 0, 8'h00);
    chk("R2 reg0 first data", reg_at(0), q[0]);
    chk("R2 reg5", reg_at(5), q[5]);
    chk("R5 reg6 written", reg_at(6), 8'h05);
    chk("R7 reg10 zero", reg_at(10), 8'h00);
    chk("R7 reg13 zero", reg_at(13), 8'h00);
    chk("R6 reg11 kept", reg_at(11), {RV_HI, 4'b0001});
    chk("R6 reg12 kept", reg_at(12), RV_LO);
    chk("R8 reg7 kept", reg_at(7), ~STRAP);
    chk("R9 reg9 written", reg_at(9), q[9]);
    for (int i = 14; i <= 20; i++) chk("R4 full groups", reg_at(i), q[i]);

    // 15 bytes: group 14-15 incomplete
    q = {};
    for (int i = 0; i < 15; i++) q.push_back(8'(i*53 + 7));
    q[6] = 8'h04;
    write_tx(q, 0, 8'h00);
    chk("R4 reg14 held", reg_at(14), mdl[14]);
    chk("R3 reg3 committed", reg_at(3), q[3]);

    // 18 bytes: 16-17 complete, 18-20 not
    q = {};
    for (int i = 0; i < 18; i++) q.push_back(8'(i*19 + 200));
    q[6] = 8'h03;
    write_tx(q, 0, 8'h00);
    chk("R4 reg15 committed", reg_at(15), q[15]);
    chk("R4 reg17 committed", reg_at(17), q[17]);
    chk("R4 reg18 held", reg_at(18), mdl[18]);

    // 6 bytes plus half a byte aimed at register 6
    q = {};
    for (int i = 0; i < 6; i++) q.push_back(8'(i*11 + 90));
    write_tx(q, 4, 8'h09);
    chk("R11 partial dropped", reg_at(6), 8'h03);
    chk("R11 prior bytes kept", reg_at(5), q[5]);

    // zero to register 6 refused
    q = {};
    for (int i = 0; i < 7; i++) q.push_back(8'(i*3 + 1));
    q[6] = 8'h00;
    write_tx(q, 0, 8'h00);
    chk("R5 zero refused", reg_at(6), 8'h03);

    // block read: count then reg0..reg2, then line released
    bus_start;
    send_byte({ADDR, 1'b1}, ack); chk("R1 read addr ack", {7'd0, ack}, 8'd1);
    recv_byte(b, 1'b0); chk("R10 count byte", b, 8'h03);
    for (int i = 0; i < 3; i++) begin
      recv_byte(b, 1'b0); chk("R10 read data", b, mdl[i]);
    end
    recv_byte(b, 1'b1); chk("R10 released after count", b, 8'hFF);
    bus_stop; settle = 1'b0;

    // command write, repeated start, read, early NACK
    bus_start;
    send_byte({ADDR, 1'b0}, ack); chk("R1 addr ack", {7'd0, ack}, 8'd1);
    send_byte(8'h00, ack);        chk("R1 cmd ack", {7'd0, ack}, 8'd1);
    bus_start;
    send_byte({ADDR, 1'b1}, ack); chk("R1 read addr ack", {7'd0, ack}, 8'd1);
    recv_byte(b, 1'b0); chk("R10 count byte rs", b, 8'h03);
    recv_byte(b, 1'b1); chk("R10 reg0 rs", b, mdl[0]);
    recv_byte(b, 1'b1); chk("R10 released after nack", b, 8'hFF);
    bus_stop; settle = 1'b0;
    hold(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule